// File: doc/BRIEF.md
# Fused Arithmetic Actor with Run-Time Variable Delay

This block is one execution element of a dataflow graph. Every pulse on its fire input makes it take two signed samples, combine them with a configured parameter through one of five selectable functions, and push the result into a private delay line. The word it presents on its output is the result of an earlier firing. How many firings earlier is set by a third input, which scales a build-time maximum delay.

Samples, the parameter and the output are signed Q16.16 words. Products are rescaled by taking the floor, and every product and sum saturates instead of wrapping. The delay control is an unsigned Q1.16 fraction. A maximum delay of zero builds a variant with no storage at all. A small configuration port selects the function and loads the parameter. Everything is clocked by one clock with a synchronous reset.

Top module: `prim_actor`

## Requirements
- R1: Function code 0 (constant) outputs the parameter and ignores both samples. Codes 5, 6 and 7 produce zero.
- R2: Code 1 (multiply-add) produces sat(sat(p·x1) + x2). Code 4 (amplify) produces sat(p·x1).
- R3: Code 2 (add) produces sat(x1 + x2). Code 3 (multiply) produces sat(x1·x2).
- R4: A Q16.16 product is the full 64-bit product arithmetically shifted right by 16, which is the floor. Any product or sum outside the 32-bit signed range is clamped to 0x7FFFFFFF or 0x80000000.
- R5: Each firing computes exactly one result and updates the output exactly once. The output changes at the clock edge on which fire is sampled high.
- R6: After firing n, the output equals the result of firing n−λn, where λn is the delay in force for that firing. If firing n−λn would come before the last reset, the output is zero.
- R7: The delay for the next firing is taken from tau at the current firing and equals min(Λ, floor(Λ·tau/65536)), with tau a 17-bit unsigned value. Right after reset the delay is zero. Λ defaults to 12.
- R8: With a delay of zero, the result of a firing appears on the output at the same edge.
- R9: While fire is low, the output holds its value whatever the samples, tau and the configuration do.
- R10: A configuration write (cfg_we high) loads the function code and the parameter. A firing on the same edge still uses the configuration held before that write.
- R11: Synchronous reset zeroes the output, every delay-line entry and the delay. It also sets the function to constant with a parameter of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_func | input | 3 | Function code to load |
| cfg_param | input | 32 | Q16.16 parameter to load |
| fire | input | 1 | Fire strobe, one firing per high cycle |
| x1 | input | 32 | First Q16.16 sample |
| x2 | input | 32 | Second Q16.16 sample |
| tau | input | 17 | Q1.16 delay control |
| y | output | 32 | Delayed Q16.16 result |

## Verification
Two events can share one edge. A configuration write can coincide with a firing. A delay change can also coincide with the firing whose result it does not yet affect, because a new tau applies only from the following firing. The bench drives cfg_we and fire high together, both in directed steps and at random in a long random run. It also changes tau on every firing. Each output is judged against a bench model that applies the old configuration and the old delay to the current firing, and the new ones only to the firings after it.

// File: rtl/pa_pkg.sv
package pa_pkg;

   typedef enum logic [2:0] {
      FN_CONST = 3'd0,
      FN_MADD  = 3'd1,
      FN_ADD   = 3'd2,
      FN_MUL   = 3'd3,
      FN_AMP   = 3'd4
   } pa_func_e;

   localparam int FUNC_W = 3;

endpackage

// File: rtl/pa_alu.sv
module pa_alu #(
   parameter int DATA_W = 32,
   parameter int FRAC_W = 16
) (
   input  logic [pa_pkg::FUNC_W-1:0] func,
   input  logic [DATA_W-1:0]         p,
   input  logic [DATA_W-1:0]         a,
   input  logic [DATA_W-1:0]         b,
   output logic [DATA_W-1:0]         res
);
   import pa_pkg::*;

   localparam int PW = 2 * DATA_W;
   localparam logic [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

   if (FRAC_W <= 0 || FRAC_W >= DATA_W) begin : g_bad_frac
      $error("pa_alu: FRAC_W must lie strictly between 0 and DATA_W");
   end

   function automatic logic [DATA_W-1:0] fx_mul(input logic [DATA_W-1:0] u,
                                                input logic [DATA_W-1:0] v);
      logic signed [PW-1:0] full;
      logic signed [PW-1:0] shd;
      logic [PW-DATA_W:0]   hi;
      full = $signed({{DATA_W{u[DATA_W-1]}}, u}) * $signed({{DATA_W{v[DATA_W-1]}}, v});
      shd  = full >>> FRAC_W;
      hi   = shd[PW-1:DATA_W-1];
      if (hi == '0 || hi == '1) return shd[DATA_W-1:0];
      return shd[PW-1] ? MINV : MAXV;
   endfunction

   function automatic logic [DATA_W-1:0] fx_add(input logic [DATA_W-1:0] u,
                                                input logic [DATA_W-1:0] v);
      logic [DATA_W:0] s;
      s = {u[DATA_W-1], u} + {v[DATA_W-1], v};
      if (s[DATA_W] == s[DATA_W-1]) return s[DATA_W-1:0];
      return s[DATA_W] ? MINV : MAXV;
   endfunction

   logic [DATA_W-1:0] p_x1;
   logic [DATA_W-1:0] x1_x2;

   assign p_x1  = fx_mul(p, a);
   assign x1_x2 = fx_mul(a, b);

   always_comb begin
      case (func)
         FN_CONST: res = p;
         FN_MADD:  res = fx_add(p_x1, b);
         FN_ADD:   res = fx_add(a, b);
         FN_MUL:   res = x1_x2;
         FN_AMP:   res = p_x1;
         default:  res = '0;
      endcase
   end

endmodule

// File: rtl/pa_delay_calc.sv
module pa_delay_calc #(
   parameter int MAX_DLY    = 12,
   parameter int TAU_FRAC_W = 16,
   parameter int TAU_W      = TAU_FRAC_W + 1,
   parameter int DLY_W      = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [TAU_W-1:0] tau,
   output logic [DLY_W-1:0] lam
);
   localparam int PRW = TAU_W + DLY_W + 1;

   if (MAX_DLY < 0) begin : g_bad_max
      $error("pa_delay_calc: MAX_DLY must be non-negative");
   end
   if (MAX_DLY >= (1 << DLY_W)) begin : g_bad_w
      $error("pa_delay_calc: DLY_W too narrow for MAX_DLY");
   end

   logic [PRW-1:0] prod;
   logic [PRW-1:0] scaled;

   assign prod   = PRW'(MAX_DLY) * PRW'(tau);
   assign scaled = prod >> TAU_FRAC_W;
   assign lam    = (scaled > PRW'(MAX_DLY)) ? DLY_W'(MAX_DLY) : scaled[DLY_W-1:0];

   AST_LAM_CLAMP: assert property (@(posedge clk) disable iff (rst)
      lam <= DLY_W'(MAX_DLY)); // R7
   AST_LAM_FULL: assert property (@(posedge clk) disable iff (rst)
      (tau >= TAU_W'(1 << TAU_FRAC_W)) |-> (lam == DLY_W'(MAX_DLY))); // R7

endmodule

// File: rtl/pa_delay_line.sv
module pa_delay_line #(
   parameter int DATA_W  = 32,
   parameter int MAX_DLY = 12,
   parameter int DLY_W   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  logic [DLY_W-1:0]  lam,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   if (MAX_DLY == 0) begin : g_nodelay
      always_ff @(posedge clk) begin
         if (rst)       dout <= '0;
         else if (fire) dout <= din;
      end

      AST_NO_DELAY: assert property (@(posedge clk) disable iff (rst)
         lam == '0); // R7
   end else begin : g_ring
      localparam int DEPTH = MAX_DLY + 1;
      localparam int PTR_W = $clog2(DEPTH);

      logic [DATA_W-1:0] mem [DEPTH];
      logic [PTR_W-1:0]  wptr;
      logic [PTR_W-1:0]  rd_idx;

      assign rd_idx = (wptr >= PTR_W'(lam)) ? (wptr - PTR_W'(lam))
                                            : (wptr + PTR_W'(DEPTH) - PTR_W'(lam));

      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wptr <= '0;
            dout <= '0;
         end else if (fire) begin
            mem[wptr] <= din;
            dout      <= (lam == '0) ? din : mem[rd_idx];
            wptr      <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         end
      end

      AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
         wptr < PTR_W'(DEPTH)); // R6
      AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
         !fire |=> $stable(wptr)); // R5
   end

   AST_ZERO_BYPASS: assert property (@(posedge clk) disable iff (rst)
      (fire && lam == '0) |=> (dout == $past(din))); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !fire |=> $stable(dout)); // R9

endmodule

// File: rtl/prim_actor.sv
module prim_actor #(
   parameter int  DATA_W     = 32,
   parameter int  FRAC_W     = 16,
   parameter int  TAU_FRAC_W = 16,
   parameter int  MAX_DLY    = 12,
   localparam int TAU_W      = TAU_FRAC_W + 1,
   localparam int DLY_W      = (MAX_DLY > 0) ? $clog2(MAX_DLY + 1) : 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cfg_we,
   input  logic [pa_pkg::FUNC_W-1:0] cfg_func,
   input  logic [DATA_W-1:0]         cfg_param,
   input  logic                      fire,
   input  logic [DATA_W-1:0]         x1,
   input  logic [DATA_W-1:0]         x2,
   input  logic [TAU_W-1:0]          tau,
   output logic [DATA_W-1:0]         y
);
   import pa_pkg::*;

   logic [FUNC_W-1:0] func_q;
   logic [DATA_W-1:0] param_q;
   logic [DLY_W-1:0]  dly_q;
   logic [DLY_W-1:0]  dly_next;
   logic [DATA_W-1:0] result;

   always_ff @(posedge clk) begin
      if (rst) begin
         func_q  <= FUNC_W'(FN_CONST);
         param_q <= '0;
      end else if (cfg_we) begin
         func_q  <= cfg_func;
         param_q <= cfg_param;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)       dly_q <= '0;
      else if (fire) dly_q <= dly_next;
   end

   pa_alu #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_alu (
      .func (func_q),
      .p    (param_q),
      .a    (x1),
      .b    (x2),
      .res  (result)
   );

   pa_delay_calc #(
      .MAX_DLY(MAX_DLY), .TAU_FRAC_W(TAU_FRAC_W), .TAU_W(TAU_W), .DLY_W(DLY_W)
   ) u_calc (
      .clk (clk),
      .rst (rst),
      .tau (tau),
      .lam (dly_next)
   );

   pa_delay_line #(.DATA_W(DATA_W), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_line (
      .clk  (clk),
      .rst  (rst),
      .fire (fire),
      .lam  (dly_q),
      .din  (result),
      .dout (y)
   );

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (y == '0)); // R11
   AST_CONST_OUT: assert property (@(posedge clk) disable iff (rst)
      (fire && func_q == FUNC_W'(FN_CONST) && dly_q == '0) |=> (y == $past(param_q))); // R1
   AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
      cfg_we |=> (func_q == $past(cfg_func) && param_q == $past(cfg_param))); // R10
   AST_DLY_HOLD: assert property (@(posedge clk) disable iff (rst)
      !fire |=> $stable(dly_q)); // R7

endmodule

// File: tb/prim_actor_bench.sv
module prim_actor_bench;
   localparam int LMAX = 12;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_func = '0;
   logic [31:0] cfg_param = '0;
   logic        fire = 1'b0;
   logic [31:0] x1 = '0;
   logic [31:0] x2 = '0;
   logic [16:0] tau = '0;
   logic [31:0] y;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] hist [1024];
   int          n_fire = 0;
   int          m_dly = 0;
   logic [2:0]  m_func = '0;
   logic [31:0] m_param = '0;

   always #2 clk = ~clk;

   prim_actor #(.MAX_DLY(LMAX)) u_prim_actor (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_func(cfg_func),
      .cfg_param(cfg_param), .fire(fire), .x1(x1), .x2(x2), .tau(tau), .y(y)
   );

   function automatic logic [31:0] sat64(input longint v);
      if (v > 64'sd2147483647)  return 32'h7FFF_FFFF;
      if (v < -64'sd2147483648) return 32'h8000_0000;
      return v[31:0];
   endfunction

   function automatic logic [31:0] mmul(input logic [31:0] a, input logic [31:0] b);
      longint pr;
      pr = longint'($signed(a)) * longint'($signed(b));
      return sat64(pr >>> 16);
   endfunction

   function automatic logic [31:0] madd(input logic [31:0] a, input logic [31:0] b);
      return sat64(longint'($signed(a)) + longint'($signed(b)));
   endfunction

   function automatic logic [31:0] model(input logic [2:0] f, input logic [31:0] p,
                                         input logic [31:0] a, input logic [31:0] b);
      case (f)
         3'd0:    return p;
         3'd1:    return madd(mmul(p, a), b);
         3'd2:    return madd(a, b);
         3'd3:    return mmul(a, b);
         3'd4:    return mmul(p, a);
         default: return 32'h0;
      endcase
   endfunction

   function automatic int lam_model(input logic [16:0] t);
      longint v;
      v = (longint'(LMAX) * longint'(t)) >> 16;
      return (v > LMAX) ? LMAX : int'(v);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic fire_op(input logic [31:0] a, input logic [31:0] b, input logic [16:0] t,
                          input bit wcfg, input logic [2:0] nf, input logic [31:0] np,
                          input string tag);
      logic [31:0] exp;
      hist[n_fire] = model(m_func, m_param, a, b);
      exp = (n_fire >= m_dly) ? hist[n_fire - m_dly] : 32'h0;
      x1 = a; x2 = b; tau = t; fire = 1'b1;
      cfg_we = wcfg; cfg_func = nf; cfg_param = np;
      @(negedge clk);
      fire = 1'b0; cfg_we = 1'b0;
      chk(tag, y, exp);
      n_fire++;
      m_dly = lam_model(t);
      if (wcfg) begin m_func = nf; m_param = np; end
   endtask

   task automatic set_cfg(input logic [2:0] f, input logic [31:0] p);
      cfg_we = 1'b1; cfg_func = f; cfg_param = p;
      @(negedge clk);
      cfg_we = 1'b0;
      m_func = f; m_param = p;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R11 reset output", y, 32'h0);
      rst = 1'b0;
      n_fire = 0; m_dly = 0; m_func = '0; m_param = '0;
   endtask

   function automatic logic [31:0] rnd_data();
      if ($urandom_range(0, 1) == 0) return $urandom_range(0, 32'h0008_0000) - 32'h0004_0000;
      return $urandom;
   endfunction

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20150916));
      @(negedge clk);
      do_reset();

      // R1 constant ignores samples, R8 zero delay
      set_cfg(3'd0, 32'h0003_0000);
      fire_op(32'h1234_5678, 32'h8765_4321, 17'h0, 0, 0, 0, "R1 R8 const");
      fire_op(32'hFFFF_0000, 32'h0000_0001, 17'h0, 0, 0, 0, "R1 const");
      // R2
      set_cfg(3'd1, 32'h0002_0000);
      fire_op(32'h0001_8000, 32'h0000_4000, 17'h0, 0, 0, 0, "R2 madd");
      set_cfg(3'd4, 32'hFFFF_8000);
      fire_op(32'h0003_0000, 32'h7777_7777, 17'h0, 0, 0, 0, "R2 amp");
      // R3
      set_cfg(3'd2, 32'h0);
      fire_op(32'hFFFE_0000, 32'h0000_8000, 17'h0, 0, 0, 0, "R3 add");
      set_cfg(3'd3, 32'h0);
      fire_op(32'hFFFE_0000, 32'h0001_8000, 17'h0, 0, 0, 0, "R3 mul");
      // R4 floor and saturation
      fire_op(32'h0000_0001, 32'h0000_0001, 17'h0, 0, 0, 0, "R4 floor pos");
      fire_op(32'hFFFF_FFFF, 32'h0000_0001, 17'h0, 0, 0, 0, "R4 floor neg");
      fire_op(32'h7FFF_0000, 32'h0002_0000, 17'h0, 0, 0, 0, "R4 mul sat hi");
      fire_op(32'h7FFF_0000, 32'hFFFE_0000, 17'h0, 0, 0, 0, "R4 mul sat lo");
      set_cfg(3'd2, 32'h0);
      fire_op(32'h7FFF_FFFF, 32'h0000_0001, 17'h0, 0, 0, 0, "R4 add sat hi");
      fire_op(32'h8000_0000, 32'hFFFF_FFFF, 17'h0, 0, 0, 0, "R4 add sat lo");
      set_cfg(3'd1, 32'h7FFF_0000);
      fire_op(32'h0004_0000, 32'hFFFF_FFFF, 17'h0, 0, 0, 0, "R4 madd sat then add");
      set_cfg(3'd6, 32'h0001_0000);
      fire_op(32'h0001_0000, 32'h0001_0000, 17'h0, 0, 0, 0, "R1 unused code");

      // R6 R7 delay changes, including clamp and fractional tau
      set_cfg(3'd2, 32'h0);
      fire_op(32'h0000_0100, 32'h0, 17'h1_0000, 0, 0, 0, "R7 set full");
      for (int i = 0; i < 16; i++)
         fire_op(32'h0001_0000 * i, 32'h5, 17'h1_0000, 0, 0, 0, "R6 full delay");
      fire_op(32'h0000_0AAA, 32'h0, 17'h1_FFFF, 0, 0, 0, "R7 clamp");
      fire_op(32'h0000_0BBB, 32'h0, 17'h0_8000, 0, 0, 0, "R6 max delay");
      fire_op(32'h0000_0CCC, 32'h0, 17'h0_5555, 0, 0, 0, "R7 half");
      fire_op(32'h0000_0DDD, 32'h0, 17'h0_0000, 0, 0, 0, "R7 floor third");
      fire_op(32'h0000_0EEE, 32'h0, 17'h0_0000, 0, 0, 0, "R8 back to zero");

      // R9 hold while idle, inputs wiggling
      begin
         logic [31:0] held;
         held = y;
         for (int i = 0; i < 6; i++) begin
            x1 = $urandom; x2 = $urandom; tau = 17'($urandom);
            cfg_param = $urandom;
            @(negedge clk);
            chk("R9 idle hold", y, held);
         end
      end
      set_cfg(3'd0, 32'h0000_0000);
      // R9 R5 delay register unchanged by idle tau: still zero
      fire_op(32'h1, 32'h2, 17'h0, 0, 0, 0, "R5 R9 delay kept");

      // R10 configuration write on the firing edge
      set_cfg(3'd0, 32'h0000_1111);
      fire_op(32'h5, 32'h6, 17'h0, 1, 3'd0, 32'h0000_2222, "R10 old param used");
      fire_op(32'h5, 32'h6, 17'h0, 1, 3'd2, 32'h0, "R10 new param used");
      fire_op(32'h0001_0000, 32'h0002_0000, 17'h0, 0, 0, 0, "R10 new func");

      // R11 mid-run reset clears storage, delay and config
      set_cfg(3'd2, 32'h0);
      for (int i = 0; i < 14; i++)
         fire_op(32'h0100_0000 + i, 32'h0, 17'h1_0000, 0, 0, 0, "R6 fill");
      do_reset();
      fire_op(32'h0009_0000, 32'h1, 17'h1_0000, 0, 0, 0, "R11 config cleared");
      set_cfg(3'd2, 32'h0);
      for (int i = 0; i < 14; i++)
         fire_op(32'h0000_0100 + i, 32'h0, 17'h1_0000, 0, 0, 0, "R11 memory cleared");

      // random phase
      for (int i = 0; i < 600; i++) begin
         logic [2:0]  f;
         logic [31:0] p;
         bit          w;
         w = ($urandom_range(0, 7) == 0);
         f = 3'($urandom_range(0, 7));
         p = rnd_data();
         if (n_fire >= 1000) do_reset();
         if ($urandom_range(0, 9) == 0) @(negedge clk);
         fire_op(rnd_data(), rnd_data(), 17'($urandom_range(0, 17'h1_FFFF)), w, f, p,
                 "R2 R3 R6 R10 random");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule